// File: doc/BRIEF.md
# Privilege-Aware Virtual Segment Decoder

This block sorts a 64-bit virtual address into one of four segment classes: mapped (the address must go through translation), cached-unmapped, uncached-unmapped (both are direct windows onto physical space), or unused (any access faults). The address map it uses depends on the current privilege level, which can be kernel, supervisor or user. Each level also has its own wide-addressing enable bit in the processor status word. When the enable bit of the active level is clear, the 32-bit map applies and only sign-extended 32-bit addresses can be valid. When it is set, the 64-bit map applies.

The block keeps a copy of the privilege level and of the selected width flag. Both are loaded whenever the status word is written and are forced to kernel, 32-bit on reset. An address presented on one clock edge yields its 2-bit class on the following edge. Translation, page tables and exception generation live elsewhere. A downstream load/store path uses the class to decide whether to look up a translation, bypass it, or raise an address fault.

Top module: `vseg_classifier`

## Requirements
- R1: After synchronous reset the stored level is kernel with the 32-bit map, and `seg_class` reads 2'b11 (unused) until the first address is classified.
- R2: The level and width flag are loaded only on a clock edge where `status_wr` is 1. They apply to addresses sampled at later edges. Changes on `status_mode` or the enable bits while `status_wr` is 0 have no effect.
- R3: Level codes on `status_mode` are 2'b00 kernel, 2'b01 supervisor, 2'b10 user, and 2'b11 is treated as user. Only the active level's own enable bit (`ext_kern`, `ext_super`, `ext_user`) selects the 64-bit map. The bits of the other levels are ignored.
- R4: With the 32-bit map, any address whose bits 63:31 are not all equal is unused.
- R5: In 32-bit kernel mode, the low 32 bits classify as follows: 0x00000000–0x7FFFFFFF is mapped, 0xC0000000–0xFFFFFFFF is mapped, 0xA0000000–0xBFFFFFFF is uncached, and 0x80000000–0x9FFFFFFF is cached.
- R6: In 32-bit supervisor mode, 0x00000000–0x7FFFFFFF and 0xC0000000–0xDFFFFFFF are mapped and the rest is unused. In 32-bit user mode, only 0x00000000–0x7FFFFFFF is mapped.
- R7: In 64-bit kernel mode, the following ranges are mapped: 0 through 0x000000FFFFFFFFFF, and 0x4000000000000000 through 0x400000FFFFFFFFFF. All other addresses below 0x8000000000000000 are unused.
- R8: In 64-bit kernel mode, addresses 0x8000000000000000–0xBFFFFFFFFFFFFFFF are split by bits 63:59 into direct regions. Only the first 4 GB of each region, where bits 58:32 are zero, is valid; the rest is unused. That window is uncached when bits 63:59 are 5'b10010 and cached otherwise.
- R9: In 64-bit kernel mode, the following hold from 0xC000000000000000 upward. Addresses through 0xC00000FF7FFFFFFF are mapped. Addresses through 0xFFFFFFFF7FFFFFFF are unused. The top 2 GB is cached (…80000000–…9FFFFFFF), then uncached (…A0000000–…BFFFFFFF), then mapped up to the end.
- R10: In 64-bit supervisor mode, the following are mapped and all else is unused: the low 1 TB, 0x4000000000000000–0x400000FFFFFFFFFF, and 0xFFFFFFFFC0000000–0xFFFFFFFFDFFFFFFF. In 64-bit user mode, only the low 1 TB is mapped.
- R11: `seg_class` encodes 2'b00 mapped, 2'b01 cached, 2'b10 uncached, 2'b11 unused. It shows the class of the `vaddr` sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_wr | input | 1 | Status word write strobe |
| status_mode | input | 2 | Privilege level being written |
| ext_kern | input | 1 | Kernel wide-addressing enable being written |
| ext_super | input | 1 | Supervisor wide-addressing enable being written |
| ext_user | input | 1 | User wide-addressing enable being written |
| vaddr | input | 64 | Virtual address to classify |
| seg_class | output | 2 | Registered segment class |

## Verification
The class is due exactly one rising edge after its address is sampled. A status write changes the outcome for addresses sampled from the edge after the write onward. The driver changes inputs only on falling edges and pushes one expected class per address into a queue. The monitor pops and compares one entry a short delay after each rising edge. Cycles spent on status writes push nothing, so every result is compared on the edge where it first appears.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int VA_W   = 64;
  localparam int LOW_W  = 32;

  typedef enum logic [1:0] {
    SEG_MAPPED   = 2'b00,
    SEG_CACHED   = 2'b01,
    SEG_UNCACHED = 2'b10,
    SEG_UNUSED   = 2'b11
  } seg_class_e;

  typedef enum logic [1:0] {
    LVL_KERN  = 2'b00,
    LVL_SUPER = 2'b01,
    LVL_USER  = 2'b10
  } level_e;

  // Upper bounds of the 64-bit priority chains
  localparam logic [63:0] XUSEG_END   = 64'h0000_00FF_FFFF_FFFF;
  localparam logic [63:0] HOLE0_END   = 64'h3FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] XSSEG_END   = 64'h4000_00FF_FFFF_FFFF;
  localparam logic [63:0] HOLE1_END   = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] PHYS_END    = 64'hBFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] XKSEG_END   = 64'hC000_00FF_7FFF_FFFF;
  localparam logic [63:0] HOLE2_END   = 64'hFFFF_FFFF_7FFF_FFFF;
  localparam logic [63:0] CK0_END     = 64'hFFFF_FFFF_9FFF_FFFF;
  localparam logic [63:0] CK1_END     = 64'hFFFF_FFFF_BFFF_FFFF;
  localparam logic [63:0] CK2_END     = 64'hFFFF_FFFF_DFFF_FFFF;
  localparam logic [4:0]  PHYS_UC_SEL = 5'b10010;
endpackage

// File: rtl/vseg_status_reg.sv
module vseg_status_reg
  import vseg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [1:0] mode_in,
  input  logic       ext_k,
  input  logic       ext_s,
  input  logic       ext_u,
  output level_e     level_q,
  output logic       wide_q
);
  level_e lvl_next;
  logic   wide_next;

  always_comb begin
    unique case (mode_in)
      2'b00:   begin lvl_next = LVL_KERN;  wide_next = ext_k; end
      2'b01:   begin lvl_next = LVL_SUPER; wide_next = ext_s; end
      default: begin lvl_next = LVL_USER;  wide_next = ext_u; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= LVL_KERN;
      wide_q  <= 1'b0;
    end else if (wr) begin
      level_q <= lvl_next;
      wide_q  <= wide_next;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(level_q) && $stable(wide_q)))
    else $error("level/width changed without a status write");

  p_reset_kernel_r1: assert property (@(posedge clk)
    rst |=> (level_q == LVL_KERN && !wide_q))
    else $error("reset did not restore kernel 32-bit");
endmodule

// File: rtl/vseg_map32.sv
module vseg_map32
  import vseg_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  level_e          level,
  output seg_class_e      cls
);
  logic [LOW_W-1:0] lo;
  logic             sext_ok;

  assign lo      = va[LOW_W-1:0];
  assign sext_ok = (&va[VA_W-1:LOW_W-1]) || !(|va[VA_W-1:LOW_W-1]);

  always_comb begin
    cls = SEG_UNUSED;
    if (sext_ok) begin
      unique case (level)
        LVL_KERN: begin
          if      (lo <= 32'h7FFF_FFFF) cls = SEG_MAPPED;
          else if (lo <= 32'h9FFF_FFFF) cls = SEG_CACHED;
          else if (lo <= 32'hBFFF_FFFF) cls = SEG_UNCACHED;
          else                          cls = SEG_MAPPED;
        end
        LVL_SUPER: begin
          if      (lo <= 32'h7FFF_FFFF) cls = SEG_MAPPED;
          else if (lo <= 32'hBFFF_FFFF) cls = SEG_UNUSED;
          else if (lo <= 32'hDFFF_FFFF) cls = SEG_MAPPED;
          else                          cls = SEG_UNUSED;
        end
        default: begin
          if (lo <= 32'h7FFF_FFFF) cls = SEG_MAPPED;
          else                     cls = SEG_UNUSED;
        end
      endcase
    end
  end
endmodule

// File: rtl/vseg_map64.sv
module vseg_map64
  import vseg_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  level_e          level,
  output seg_class_e      cls
);
  seg_class_e phys_cls;

  // Direct region: only its first 4 GB window is populated
  always_comb begin
    if (va[58:32] != '0)               phys_cls = SEG_UNUSED;
    else if (va[63:59] == PHYS_UC_SEL) phys_cls = SEG_UNCACHED;
    else                               phys_cls = SEG_CACHED;
  end

  always_comb begin
    cls = SEG_UNUSED;
    unique case (level)
      LVL_KERN: begin
        if      (va <= XUSEG_END) cls = SEG_MAPPED;
        else if (va <= HOLE0_END) cls = SEG_UNUSED;
        else if (va <= XSSEG_END) cls = SEG_MAPPED;
        else if (va <= HOLE1_END) cls = SEG_UNUSED;
        else if (va <= PHYS_END)  cls = phys_cls;
        else if (va <= XKSEG_END) cls = SEG_MAPPED;
        else if (va <= HOLE2_END) cls = SEG_UNUSED;
        else if (va <= CK0_END)   cls = SEG_CACHED;
        else if (va <= CK1_END)   cls = SEG_UNCACHED;
        else                      cls = SEG_MAPPED;
      end
      LVL_SUPER: begin
        if      (va <= XUSEG_END) cls = SEG_MAPPED;
        else if (va <= HOLE0_END) cls = SEG_UNUSED;
        else if (va <= XSSEG_END) cls = SEG_MAPPED;
        else if (va <= CK1_END)   cls = SEG_UNUSED;
        else if (va <= CK2_END)   cls = SEG_MAPPED;
        else                      cls = SEG_UNUSED;
      end
      default: begin
        if (va <= XUSEG_END) cls = SEG_MAPPED;
        else                 cls = SEG_UNUSED;
      end
    endcase
  end
endmodule

// File: rtl/vseg_classifier.sv
module vseg_classifier
  import vseg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            status_wr,
  input  logic [1:0]      status_mode,
  input  logic            ext_kern,
  input  logic            ext_super,
  input  logic            ext_user,
  input  logic [VA_W-1:0] vaddr,
  output logic [1:0]      seg_class
);
  level_e     level_q;
  logic       wide_q;
  seg_class_e cls32, cls64;
  seg_class_e cls_q;

  vseg_status_reg u_status (
    .clk     (clk),
    .rst     (rst),
    .wr      (status_wr),
    .mode_in (status_mode),
    .ext_k   (ext_kern),
    .ext_s   (ext_super),
    .ext_u   (ext_user),
    .level_q (level_q),
    .wide_q  (wide_q)
  );

  vseg_map32 u_map32 (.va(vaddr), .level(level_q), .cls(cls32));
  vseg_map64 u_map64 (.va(vaddr), .level(level_q), .cls(cls64));

  always_ff @(posedge clk) begin
    if (rst) cls_q <= SEG_UNUSED;
    else     cls_q <= wide_q ? cls64 : cls32;
  end

  assign seg_class = cls_q;

  p_reset_unused_r1: assert property (@(posedge clk)
    rst |=> (seg_class == SEG_UNUSED))
    else $error("class not unused after reset");

  p_narrow_sext_r4: assert property (@(posedge clk) disable iff (rst)
    (!wide_q && (vaddr[63:31] != '0) && (vaddr[63:31] != '1)) |=> (seg_class == SEG_UNUSED))
    else $error("non-sign-extended address accepted in 32-bit map");

  p_user_class_r6: assert property (@(posedge clk) disable iff (rst)
    (level_q == LVL_USER) |=> (seg_class == SEG_MAPPED || seg_class == SEG_UNUSED))
    else $error("user level produced a direct window");

  p_super_no_direct_r10: assert property (@(posedge clk) disable iff (rst)
    (level_q == LVL_SUPER) |=> (seg_class == SEG_MAPPED || seg_class == SEG_UNUSED))
    else $error("supervisor level produced a direct window");
endmodule

// File: tb/vseg_classifier_tb.sv
module vseg_classifier_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        status_wr = 1'b0;
  logic [1:0]  status_mode = 2'b00;
  logic        ext_kern = 1'b0, ext_super = 1'b0, ext_user = 1'b0;
  logic [63:0] vaddr = '0;
  logic [1:0]  seg_class;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [1:0]  exp;
    logic [63:0] addr;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  vseg_classifier u_dut (
    .clk(clk), .rst(rst), .status_wr(status_wr), .status_mode(status_mode),
    .ext_kern(ext_kern), .ext_super(ext_super), .ext_user(ext_user),
    .vaddr(vaddr), .seg_class(seg_class)
  );

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag, input logic [63:0] a);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%b expected=%b", tag, a, act, exp);
    end
  endtask

  task automatic classify(input logic [63:0] a, input logic [1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    vaddr = a;
    it.exp = exp; it.addr = a; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr_status(input logic [1:0] m, input logic k, input logic s, input logic u);
    @(negedge clk);
    status_wr = 1'b1; status_mode = m; ext_kern = k; ext_super = s; ext_user = u;
    @(negedge clk);
    status_wr = 1'b0;
    @(posedge clk);
  endtask

  // monitor: one result due one edge after each queued address
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(seg_class, it.exp, it.tag, it.addr);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(seg_class, 2'b11, "R1 reset class", 64'h0);

    // R1/R5: reset state is kernel 32-bit
    classify(64'h0000_0000_1234_5678, 2'b00, "R5 kuseg");
    classify(64'hFFFF_FFFF_8000_0010, 2'b01, "R5 cached");
    classify(64'hFFFF_FFFF_A000_0000, 2'b10, "R5 uncached lo");
    classify(64'hFFFF_FFFF_BFFF_FFFF, 2'b10, "R5 uncached hi");
    classify(64'hFFFF_FFFF_C000_0000, 2'b00, "R5 upper mapped");
    classify(64'hFFFF_FFFF_FFFF_FFFC, 2'b00, "R5 top");
    classify(64'h0000_0000_8000_0000, 2'b11, "R4 not sext");
    classify(64'h0000_0001_0000_0000, 2'b11, "R4 high bits");

    // R3: user level 32-bit, kernel enable ignored
    wr_status(2'b10, 1'b1, 1'b0, 1'b0);
    classify(64'h0000_0000_7FFF_FFFF, 2'b00, "R6 user mapped");
    classify(64'hFFFF_FFFF_8000_0000, 2'b11, "R6 user high");
    classify(64'h0000_0010_0000_0000, 2'b11, "R3 user narrow");

    // R2: enable changes without a write have no effect
    @(negedge clk);
    ext_user = 1'b1; status_mode = 2'b00;
    classify(64'h0000_0001_0000_0000, 2'b11, "R2 no write");

    // R10: user 64-bit
    wr_status(2'b10, 1'b0, 1'b0, 1'b1);
    classify(64'h0000_0001_0000_0000, 2'b00, "R10 user wide");
    classify(64'h0000_00FF_FFFF_FFFF, 2'b00, "R10 user 1TB edge");
    classify(64'h0000_0100_0000_0000, 2'b11, "R10 user past 1TB");
    classify(64'hFFFF_FFFF_8000_0000, 2'b11, "R10 user top");

    // R6/R3: supervisor 32-bit with kernel enable set
    wr_status(2'b01, 1'b1, 1'b0, 1'b1);
    classify(64'h0000_0000_0000_0000, 2'b00, "R6 sup low");
    classify(64'hFFFF_FFFF_9000_0000, 2'b11, "R6 sup hole");
    classify(64'hFFFF_FFFF_C000_0000, 2'b00, "R6 sup sseg");
    classify(64'hFFFF_FFFF_E000_0000, 2'b11, "R6 sup top");

    // R10: supervisor 64-bit
    wr_status(2'b01, 1'b0, 1'b1, 1'b0);
    classify(64'h0000_00FF_FFFF_FFFF, 2'b00, "R10 sup low");
    classify(64'h2000_0000_0000_0000, 2'b11, "R10 sup hole");
    classify(64'h4000_0000_0000_1000, 2'b00, "R10 sup xsseg");
    classify(64'h4000_0100_0000_0000, 2'b11, "R10 sup past xsseg");
    classify(64'hFFFF_FFFF_8000_0000, 2'b11, "R10 sup below csseg");
    classify(64'hFFFF_FFFF_C000_0000, 2'b00, "R10 sup csseg");
    classify(64'hFFFF_FFFF_E000_0000, 2'b11, "R10 sup above csseg");

    // R7/R8/R9: kernel 64-bit
    wr_status(2'b00, 1'b1, 1'b0, 1'b0);
    classify(64'h0000_00FF_FFFF_FFFF, 2'b00, "R7 xkuseg edge");
    classify(64'h0000_0100_0000_0000, 2'b11, "R7 hole0");
    classify(64'h4000_00FF_FFFF_FFFF, 2'b00, "R7 xksseg edge");
    classify(64'h7000_0000_0000_0000, 2'b11, "R7 hole1");
    classify(64'h8000_0000_1234_5678, 2'b01, "R8 window 10000");
    classify(64'h8000_0001_0000_0000, 2'b11, "R8 beyond 4GB");
    classify(64'h8800_0000_0000_0000, 2'b01, "R8 window 10001");
    classify(64'h9000_0000_0000_0000, 2'b10, "R8 uncached lo");
    classify(64'h9000_0000_FFFF_FFFF, 2'b10, "R8 uncached hi");
    classify(64'h9800_0000_0000_0000, 2'b01, "R8 window 10011");
    classify(64'hB800_0000_FFFF_FFF0, 2'b01, "R8 window 10111");
    classify(64'hC000_00FF_7FFF_FFFF, 2'b00, "R9 xkseg edge");
    classify(64'hC000_00FF_8000_0000, 2'b11, "R9 hole2");
    classify(64'hFFFF_FFFF_8000_0000, 2'b01, "R9 ck cached");
    classify(64'hFFFF_FFFF_A000_0000, 2'b10, "R9 ck uncached");
    classify(64'hFFFF_FFFF_E000_0000, 2'b00, "R9 ck mapped");

    // R3: code 11 behaves as user; kernel enable ignored
    wr_status(2'b11, 1'b1, 1'b1, 1'b0);
    classify(64'hFFFF_FFFF_8000_0000, 2'b11, "R3 code11 high");
    classify(64'h0000_0000_0000_0010, 2'b00, "R3 code11 low");
    classify(64'h0000_0001_0000_0000, 2'b11, "R3 code11 narrow");

    // R11: back-to-back addresses, one result per edge
    classify(64'h0000_0000_0000_0020, 2'b00, "R11 seq a");
    classify(64'h0000_0001_0000_0020, 2'b11, "R11 seq b");

    repeat (3) @(posedge clk);
    #2;
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R11 results missing actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule